// File: doc/BRIEF.md
# Binary/BCD Add-Subtract Unit

This block is the add-with-carry and subtract-with-borrow stage of an 8-bit processor datapath. It takes the accumulator, an operand, the carry flag, the decimal-mode flag and an add/subtract select. It returns the 8-bit result and the negative, overflow, zero and carry flags. In binary mode it behaves as an ordinary two's-complement adder and subtractor. In decimal mode it applies packed-BCD digit correction. The flags follow the behaviour of the classic NMOS parts, which is irregular in decimal mode, and software written for those parts relies on it.

In decimal addition the zero flag reflects the plain binary sum. The negative and overflow flags are taken from the high digit after the low-digit carry has been added but before that digit is corrected. In decimal subtraction the result is digit-corrected, while every flag is taken from the binary difference. Operand bytes that are not valid BCD are not rejected: they pass through the same nibble arithmetic and give deterministic results.

By default the unit registers its outputs and raises a valid strobe one cycle after a request. A parameter can select a purely combinational variant instead.

Top module: `bcd_addsub_alu`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), out_valid is 0 and result, flag_n, flag_v, flag_z and flag_c are all 0. in_valid is ignored while reset is held.
- R2: With the default registered variant, out_valid is 1 in exactly the cycle after a cycle with in_valid 1. While in_valid is 0, result and all four flags hold their last values.
- R3: Binary add (sub_sel=0, dec_mode=0) gives T = A + B + carry_in. result = T mod 256, C = T > 255, N = result bit 7, Z = (result == 0). V = 1 when A and B have the same bit 7 and the result's bit 7 differs from it.
- R4: Binary subtract (sub_sel=1, dec_mode=0) gives T = A − B − (1 − carry_in). result = T mod 256, and C = 1 when no borrow occurs (T ≥ 0). N = result bit 7, Z = (result == 0). V = 1 when A and B differ in bit 7 and A and the result differ in bit 7.
- R5: Decimal add result and carry follow these steps. lo = A[3:0] + B[3:0] + carry_in, and 6 is added to lo if lo > 9. hi = A[7:4] + B[7:4], plus 1 if lo > 15. After the flags of R7 are formed, 6 is added to hi if hi > 9. C = (hi > 15), and result = {hi[3:0], lo[3:0]}.
- R6: In decimal add, Z = 1 exactly when (A + B + carry_in) mod 256 is 0, whatever the corrected result is.
- R7: In decimal add, N = bit 3 of hi before its correction. V = 1 when A[7] equals B[7] and that uncorrected hi bit 3 differs from A[7].
- R8: Decimal subtract result follows these steps. lo = A[3:0] − B[3:0] − (1 − carry_in) and hi = A[7:4] − B[7:4], both signed. If lo is negative, 6 is subtracted from lo and 1 from hi. Then, if hi is negative, 6 is subtracted from hi. result = {hi[3:0], lo[3:0]}.
- R9: In decimal subtract, C, V, N and Z are identical to those of R4 for the same A, B and carry_in.
- R10: Operands with nibbles above 9 are accepted in decimal mode and give the results defined by R5 to R9. No input combination is rejected.
- R11: In decimal mode, when both A and B have both nibbles in 0..9, both nibbles of the result are in 0..9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe: inputs are captured in this cycle |
| sub_sel | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| dec_mode | input | 1 | 0 = binary, 1 = packed BCD |
| acc_in | input | 8 | Accumulator operand A |
| opnd_in | input | 8 | Second operand B |
| carry_in | input | 1 | Carry flag in (for subtract, 1 = no borrow) |
| out_valid | output | 1 | Result and flags are new this cycle |
| result | output | 8 | Sum or difference |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag (for subtract, 1 = no borrow) |

## Verification
The sweep covers all four mode combinations with both carry values. Every accumulator value is paired with a quarter of all operand values, and the operand steps so that every low digit, every high digit and every sign pairing occurs. The directed vectors are chosen to separate the quirks:
- Vectors such as 0x99+0x01 give a binary sum that is nonzero while the corrected BCD result wraps to zero, so Z sourced from the wrong place is exposed.
- Vectors whose uncorrected high digit sets bit 3, such as 0x79+0x01, expose N and V taken after the correction.
- Subtractions with a low-digit borrow, such as 0x10−0x01, exercise the high-digit decrement.
- All-F operands show the defined non-BCD behaviour.

Idle cycles between requests show that the output is held.

// File: rtl/alu_pkg.sv
// Package: alu_pkg
// Shared widths and types for the binary/BCD add-subtract unit.
// Assumes an 8-bit datapath made of two 4-bit digits.
package alu_pkg;

    localparam int DATA_W  = 8;
    localparam int DIGIT_W = 4;
    localparam int DIGITS  = DATA_W / DIGIT_W;
    // Digit intermediates: 4 data bits, a carry/borrow bit, and a sign guard bit
    localparam int EXT_W   = DIGIT_W + 2;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } alu_flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        alu_flags_t        flags;
    } alu_out_t;

    // True when every digit of a byte lies in 0..9
    function automatic logic is_bcd_byte(input logic [DATA_W-1:0] b);
        logic ok;
        ok = 1'b1;
        for (int d = 0; d < DIGITS; d++) begin
            if (b[d*DIGIT_W +: DIGIT_W] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/bin_path.sv
// Module: bin_path
// Two's-complement add-with-carry or subtract-with-borrow over the full byte.
// It produces the binary result and all four binary flags. The decimal paths
// reuse its Z output (decimal add) or all of its flags (decimal subtract).
// Assumes carry_in = 1 means "no borrow" when subtracting.
module bin_path
    import alu_pkg::*;
(
    input  logic              sub_sel,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              carry_in,
    output logic [DATA_W-1:0] bin_res,
    output alu_flags_t        bin_flags
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] wide;

    // Form the 9-bit sum or difference; bit 8 is the carry out or the borrow
    always_comb begin
        if (sub_sel)
            wide = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, ~carry_in};
        else
            wide = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, carry_in};
    end

    assign bin_res = wide[DATA_W-1:0];

    // Derive the flags from the binary result
    always_comb begin
        bin_flags.n = wide[MSB];
        bin_flags.z = (wide[DATA_W-1:0] == '0);
        if (sub_sel) begin
            bin_flags.c = ~wide[DATA_W];
            bin_flags.v = (a[MSB] ^ b[MSB]) & (a[MSB] ^ wide[MSB]);
        end else begin
            bin_flags.c = wide[DATA_W];
            bin_flags.v = ~(a[MSB] ^ b[MSB]) & (a[MSB] ^ wide[MSB]);
        end
    end

endmodule

// File: rtl/dec_add_path.sv
// Module: dec_add_path
// Packed-BCD addition using the NMOS digit-correction order.
// N and V come from the high digit before its correction; C comes from it
// after the correction. Z is not produced here (the binary sum supplies it).
// Assumes nothing about the input digits: non-BCD nibbles go through the same
// arithmetic.
module dec_add_path
    import alu_pkg::*;
(
    input  logic              [DATA_W-1:0] a,
    input  logic              [DATA_W-1:0] b,
    input  logic                           carry_in,
    output logic              [DATA_W-1:0] dec_res,
    output logic                           dec_n,
    output logic                           dec_v,
    output logic                           dec_c
);

    localparam int MSB = DATA_W - 1;
    localparam logic [EXT_W-1:0] NINE = EXT_W'(9);
    localparam logic [EXT_W-1:0] SIX  = EXT_W'(6);
    localparam logic [EXT_W-1:0] MAXD = EXT_W'(15);

    logic [EXT_W-1:0] lo_raw, lo_fix, hi_raw, hi_fix;
    logic             lo_carry;

    // Low digit: add, then correct by 6 when it passes 9
    always_comb begin
        lo_raw   = {2'b00, a[DIGIT_W-1:0]} + {2'b00, b[DIGIT_W-1:0]}
                 + {{(EXT_W-1){1'b0}}, carry_in};
        lo_fix   = (lo_raw > NINE) ? lo_raw + SIX : lo_raw;
        lo_carry = (lo_fix > MAXD);
    end

    // High digit: add with the low-digit carry; N and V are sampled before correction
    always_comb begin
        hi_raw = {2'b00, a[DATA_W-1:DIGIT_W]} + {2'b00, b[DATA_W-1:DIGIT_W]}
               + {{(EXT_W-1){1'b0}}, lo_carry};
        dec_n  = hi_raw[DIGIT_W-1];
        dec_v  = (hi_raw[DIGIT_W-1] ^ a[MSB]) & ~(a[MSB] ^ b[MSB]);
        hi_fix = (hi_raw > NINE) ? hi_raw + SIX : hi_raw;
        dec_c  = (hi_fix > MAXD);
    end

    assign dec_res = {hi_fix[DIGIT_W-1:0], lo_fix[DIGIT_W-1:0]};

endmodule

// File: rtl/dec_sub_path.sv
// Module: dec_sub_path
// Packed-BCD subtraction of the result only. Every flag is taken from the
// binary difference elsewhere. The digit differences are held in 6-bit two's
// complement, and bit 4 of each marks a borrow. Non-BCD digits are accepted.
module dec_sub_path
    import alu_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              carry_in,
    output logic [DATA_W-1:0] dec_res
);

    localparam logic [EXT_W-1:0] SIX = EXT_W'(6);
    localparam logic [EXT_W-1:0] ONE = EXT_W'(1);

    logic [EXT_W-1:0] lo_raw, lo_fix, hi_raw, hi_dec, hi_fix;

    // Low digit difference with borrow-in, corrected when it goes negative
    always_comb begin
        lo_raw = {2'b00, a[DIGIT_W-1:0]} - {2'b00, b[DIGIT_W-1:0]}
               - {{(EXT_W-1){1'b0}}, ~carry_in};
        lo_fix = lo_raw[DIGIT_W] ? lo_raw - SIX : lo_raw;
    end

    // High digit difference, with the low-digit borrow applied and then corrected
    always_comb begin
        hi_raw = {2'b00, a[DATA_W-1:DIGIT_W]} - {2'b00, b[DATA_W-1:DIGIT_W]};
        hi_dec = lo_raw[DIGIT_W] ? hi_raw - ONE : hi_raw;
        hi_fix = hi_dec[DIGIT_W] ? hi_dec - SIX : hi_dec;
    end

    assign dec_res = {hi_fix[DIGIT_W-1:0], lo_fix[DIGIT_W-1:0]};

endmodule

// File: rtl/bcd_addsub_alu.sv
// Module: bcd_addsub_alu
// Top of the binary/BCD add-subtract unit. It runs the binary, decimal-add and
// decimal-subtract paths in parallel and picks the result and flag sources
// from sub_sel and dec_mode. With REGISTER_OUT=1 (the default) it captures the
// outcome on in_valid and raises out_valid one cycle later. Otherwise it is
// purely combinational, with out_valid equal to in_valid.
// Assumes a synchronous, active-low reset.
module bcd_addsub_alu
    import alu_pkg::*;
#(
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              sub_sel,
    input  logic              dec_mode,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic              carry_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              flag_n,
    output logic              flag_v,
    output logic              flag_z,
    output logic              flag_c
);

    logic [DATA_W-1:0] bin_res, dadd_res, dsub_res;
    alu_flags_t        bin_flags;
    logic              dadd_n, dadd_v, dadd_c;
    alu_out_t          nxt;

    bin_path u_bin (
        .sub_sel   (sub_sel),
        .a         (acc_in),
        .b         (opnd_in),
        .carry_in  (carry_in),
        .bin_res   (bin_res),
        .bin_flags (bin_flags)
    );

    dec_add_path u_dadd (
        .a        (acc_in),
        .b        (opnd_in),
        .carry_in (carry_in),
        .dec_res  (dadd_res),
        .dec_n    (dadd_n),
        .dec_v    (dadd_v),
        .dec_c    (dadd_c)
    );

    dec_sub_path u_dsub (
        .a        (acc_in),
        .b        (opnd_in),
        .carry_in (carry_in),
        .dec_res  (dsub_res)
    );

    // Pick result and flag sources; decimal add keeps only binary Z, decimal subtract keeps all binary flags
    always_comb begin
        nxt.value = bin_res;
        nxt.flags = bin_flags;
        if (dec_mode) begin
            if (sub_sel) begin
                nxt.value = dsub_res;
            end else begin
                nxt.value   = dadd_res;
                nxt.flags.n = dadd_n;
                nxt.flags.v = dadd_v;
                nxt.flags.c = dadd_c;
            end
        end
    end

    generate
        if (REGISTER_OUT) begin : g_reg
            alu_out_t held;
            logic     vld_q;

            // Capture a request's outcome; hold it while idle
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    held  <= '0;
                    vld_q <= 1'b0;
                end else begin
                    vld_q <= in_valid;
                    if (in_valid) held <= nxt;
                end
            end

            assign out_valid = vld_q;
            assign result    = held.value;
            assign flag_n    = held.flags.n;
            assign flag_v    = held.flags.v;
            assign flag_z    = held.flags.z;
            assign flag_c    = held.flags.c;

            AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (out_valid == $past(in_valid))); // R2
            AST_IDLE_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && !$past(in_valid)) |-> ($stable(result) && $stable(flag_c) && $stable(flag_z))); // R2
            AST_BIN_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && !$past(sub_sel) && !$past(dec_mode)) |->
                ({flag_c, result} == ({1'b0, $past(acc_in)} + {1'b0, $past(opnd_in)}
                                      + {{DATA_W{1'b0}}, $past(carry_in)}))); // R3
            AST_ADD_ZERO_FROM_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && !$past(sub_sel)) |->
                (flag_z == ((DATA_W'($past(acc_in) + $past(opnd_in)
                             + {{(DATA_W-1){1'b0}}, $past(carry_in)})) == '0))); // R6
            AST_SUB_CARRY_FROM_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && $past(sub_sel)) |->
                (flag_c == ({1'b0, $past(acc_in)} >= ({1'b0, $past(opnd_in)}
                                                      + {{DATA_W{1'b0}}, !$past(carry_in)})))); // R9
            AST_BCD_DIGITS_STAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && $past(dec_mode) && is_bcd_byte($past(acc_in))
                 && is_bcd_byte($past(opnd_in))) |-> is_bcd_byte(result)); // R11
        end else begin : g_comb
            assign out_valid = in_valid;
            assign result    = nxt.value;
            assign flag_n    = nxt.flags.n;
            assign flag_v    = nxt.flags.v;
            assign flag_z    = nxt.flags.z;
            assign flag_c    = nxt.flags.c;
        end
    endgenerate

endmodule

// File: tb/sim_bcd_addsub_alu.sv
// Bench for bcd_addsub_alu: a behavioural integer model predicts every
// request. The model is compared on the clock after each request, and the
// idle/hold and reset behaviour is checked at the ports.
module sim_bcd_addsub_alu;

    typedef struct {
        logic [7:0] res;
        logic       n, v, z, c;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       sub_sel = 1'b0;
    logic       dec_mode = 1'b0;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] opnd_in = 8'h00;
    logic       carry_in = 1'b0;
    logic       out_valid;
    logic [7:0] result;
    logic       flag_n, flag_v, flag_z, flag_c;

    int vectors = 0;
    int miscompares = 0;

    // Pending request waiting for its output cycle
    bit    pend = 1'b0;
    exp_t  pend_e;
    bit    pend_dec, pend_sub, pend_bcd;
    string pend_note;
    exp_t  last_e;

    always #5 clk = ~clk;

    bcd_addsub_alu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_sel(sub_sel),
        .dec_mode(dec_mode), .acc_in(acc_in), .opnd_in(opnd_in), .carry_in(carry_in),
        .out_valid(out_valid), .result(result), .flag_n(flag_n), .flag_v(flag_v),
        .flag_z(flag_z), .flag_c(flag_c)
    );

    // Integer model of the requirements
    function automatic exp_t model(int a, int b, int c, bit dec, bit sub);
        exp_t e;
        int t, lo, hi;
        t = sub ? (a - b - (1 - c)) : (a + b + c);
        e.res = 8'(t);
        e.z   = ((t & 255) == 0);
        e.n   = ((t & 128) != 0);
        if (!sub) begin
            e.c = (t > 255);
            e.v = (((~(a ^ b)) & (a ^ t) & 128) != 0);
            if (dec) begin
                lo = (a & 15) + (b & 15) + c;
                if (lo > 9) lo += 6;
                hi = (a >> 4) + (b >> 4) + ((lo > 15) ? 1 : 0);
                e.n = ((hi & 8) != 0);
                e.v = ((((hi << 4) ^ a) & 128) != 0) && (((a ^ b) & 128) == 0);
                if (hi > 9) hi += 6;
                e.c = (hi > 15);
                e.res = 8'((hi << 4) | (lo & 15));
            end
        end else begin
            e.c = (t >= 0);
            e.v = (((a ^ t) & (a ^ b) & 128) != 0);
            if (dec) begin
                lo = (a & 15) - (b & 15) - (1 - c);
                hi = (a >> 4) - (b >> 4);
                if (lo < 0) begin lo -= 6; hi -= 1; end
                if (hi < 0) hi -= 6;
                e.res = 8'((hi << 4) | (lo & 15));
            end
        end
        return e;
    endfunction

    function automatic bit bcd_ok(int v);
        return ((v & 15) <= 9) && (((v >> 4) & 15) <= 9);
    endfunction

    task automatic fail(string tag, string what, int act, int exp, string note);
        miscompares++;
        $display("FAIL %s %s actual=%0h expected=%0h (%s)", tag, what, act, exp, note);
    endtask

    // Compare the outputs against the pending request
    task automatic compare_pending();
        string tr, tf, tz, tnv;
        vectors++;
        if (!pend_dec) begin
            tr = pend_sub ? "R4" : "R3"; tf = tr; tz = tr; tnv = tr;
        end else if (!pend_sub) begin
            tr = "R5"; tf = "R5"; tz = "R6"; tnv = "R7";
        end else begin
            tr = "R8"; tf = "R9"; tz = "R9"; tnv = "R9";
        end
        if (out_valid !== 1'b1) fail("R2", "out_valid", out_valid, 1, pend_note);
        if (result !== pend_e.res) fail(tr, "result", result, pend_e.res, pend_note);
        if (flag_c !== pend_e.c) fail(tf, "C", flag_c, pend_e.c, pend_note);
        if (flag_z !== pend_e.z) fail(tz, "Z", flag_z, pend_e.z, pend_note);
        if (flag_n !== pend_e.n) fail(tnv, "N", flag_n, pend_e.n, pend_note);
        if (flag_v !== pend_e.v) fail(tnv, "V", flag_v, pend_e.v, pend_note);
        if (pend_dec && pend_bcd) begin
            vectors++;
            if (!bcd_ok(int'(result))) fail("R11", "digits", result, pend_e.res, pend_note);
        end
        last_e = pend_e;
    endtask

    // One cycle: check the previous request, then drive this one
    task automatic step(bit v, int a, int b, int c, bit dec, bit sub, string note);
        @(negedge clk);
        if (pend) compare_pending();
        pend = 1'b0;
        in_valid = v; acc_in = 8'(a); opnd_in = 8'(b); carry_in = c[0];
        dec_mode = dec; sub_sel = sub;
        if (v) begin
            pend = 1'b1; pend_e = model(a, b, c, dec, sub);
            pend_dec = dec; pend_sub = sub; pend_note = note;
            pend_bcd = bcd_ok(a) && bcd_ok(b);
        end
    endtask

    // Idle cycle whose output must show no new data and a held result (R2)
    task automatic idle_check();
        step(1'b0, 8'h5a, 8'ha5, 1, 1'b1, 1'b1, "idle");
        step(1'b0, 8'h33, 8'hcc, 0, 1'b0, 1'b0, "idle");
        vectors++;
        if (out_valid !== 1'b0) fail("R2", "out_valid idle", out_valid, 0, "hold");
        if (result !== last_e.res || flag_c !== last_e.c || flag_z !== last_e.z)
            fail("R2", "held result", result, last_e.res, "hold");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fail("watchdog", "cycles", 190000, 0, "timeout");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        // R1: reset held with a request present must leave everything cleared
        in_valid = 1'b1; acc_in = 8'hff; opnd_in = 8'hff; carry_in = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        vectors++;
        if (out_valid !== 1'b0 || result !== 8'h00 || {flag_n, flag_v, flag_z, flag_c} !== 4'b0000)
            fail("R1", "reset state", {out_valid, result, flag_n, flag_v, flag_z, flag_c}, 0, "reset");

        // Directed corner cases
        step(1'b1, 8'h7f, 8'h01, 0, 1'b0, 1'b0, "R3 signed overflow");
        step(1'b1, 8'hff, 8'h00, 1, 1'b0, 1'b0, "R3 carry to zero");
        step(1'b1, 8'h80, 8'h01, 1, 1'b0, 1'b1, "R4 signed overflow");
        step(1'b1, 8'h00, 8'h00, 0, 1'b0, 1'b1, "R4 borrow");
        idle_check();
        step(1'b1, 8'h99, 8'h01, 0, 1'b1, 1'b0, "R6 BCD wrap nonzero binary");
        step(1'b1, 8'h50, 8'h50, 0, 1'b1, 1'b0, "R5 decimal carry out");
        step(1'b1, 8'h79, 8'h01, 0, 1'b1, 1'b0, "R7 N/V from raw high digit");
        step(1'b1, 8'h10, 8'h01, 1, 1'b1, 1'b1, "R8 low borrow");
        step(1'b1, 8'h00, 8'h01, 1, 1'b1, 1'b1, "R8 wrap to 99");
        step(1'b1, 8'h00, 8'h00, 0, 1'b1, 1'b1, "R9 borrow-in flags");
        step(1'b1, 8'hff, 8'hff, 1, 1'b1, 1'b0, "R10 non-BCD add");
        step(1'b1, 8'h0f, 8'hfa, 0, 1'b1, 1'b1, "R10 non-BCD sub");
        idle_check();

        // Sweep: all modes and carries, every A, a quarter of B covering all residues
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 2; c++) begin
                for (int a = 0; a < 256; a++) begin
                    for (int j = 0; j < 64; j++) begin
                        step(1'b1, a, (j * 4 + ((a + c + m) & 3)) & 255, c,
                             m[1], m[0], "sweep R10");
                    end
                end
            end
        end
        idle_check();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule